// File: doc/BRIEF.md
# Single-Port Load/Store Memory Front End

This block sits between one load/store requester and a small byte-addressed internal memory with a 64-bit word. The requester runs one operation at a time. It raises a load flag or a store flag, gives an access length in bytes (1, 2, 4 or 8), and presents an address together with an address-valid qualifier. The block accepts the request, pulses an address acknowledgement, and then either waits for a one-cycle store strobe carrying the data or returns the load data with a one-cycle load-valid flag.

The address handshake works as a valid/ready pair with back-pressure: the address is taken only in a cycle where the block is idle (busy low), and the request flag and address-valid are both high. While busy is high the block takes no new address, and the requester must hold off. The store strobe and the load-valid flag are single-cycle qualifiers with no back-pressure. The requester samples load data in the load-valid cycle, and it may drop its flags at once without waiting for busy. Memory is little-endian. An access occupies the byte lanes from the address modulo 8 upward, and load data comes back right-justified and zero-extended.

Top module: `lsport_mem`

## Requirements
- R1: After reset, busy_o, addr_ok_o and ld_vld_o are low, ld_data_o is zero, and every memory byte reads as zero.
- R2: While idle, a clock edge with addr_vld_i high and either request flag high accepts the request. After that edge busy_o and addr_ok_o are high, and addr_ok_o falls after the following edge. With addr_vld_i low, no request is accepted.
- R3: A store writes the bytes of st_data_i[8L-1:0] (L = length) to byte addresses A..A+L-1, least significant byte at A, and leaves all other bytes unchanged. The data is taken at the first edge of the store phase where st_vld_i is high.
- R4: A load raises ld_vld_o for exactly one cycle, in the cycle after the addr_ok_o cycle. In that cycle ld_data_o holds the L bytes from A (byte A in bits 7:0), and bits above 8L are zero.
- R5: The length field len_i is an unsigned count. Only 1, 2, 4 and 8 are legal, and (A mod 8) + L must not exceed 8. For any other access a store changes no memory, and a load returns zero with ld_vld_o still pulsed.
- R6: Once the store strobe is taken or the load-valid cycle has passed, busy_o stays high while any request flag is high. It falls after the first edge with both flags low. A store strobe outside a store phase is ignored.
- R7: If both request flags are high at acceptance, the operation is a load and memory is not written.
- R8: A 2-byte store of 0xBEEF at address 2 and of 0xF00F at address 4 read back unchanged with 2-byte loads at those addresses.
- R9: In the store phase the block waits any number of cycles for st_vld_i with busy_o held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_i | input | 1 | Load operation flag, held for the whole operation |
| st_req_i | input | 1 | Store operation flag, held for the whole operation |
| len_i | input | 4 | Access length in bytes (1, 2, 4, 8) |
| addr_i | input | 8 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, right-justified |
| st_vld_i | input | 1 | Store data strobe, one cycle |
| busy_o | output | 1 | Operation in progress |
| addr_ok_o | output | 1 | Address accepted, one-cycle pulse |
| ld_data_o | output | 64 | Load data, right-justified and zero-extended |
| ld_vld_o | output | 1 | Load data valid, one-cycle pulse |

## Verification
The assertions check every cycle that addr_ok_o and ld_vld_o are single-cycle pulses, and that an idle cycle with a valid request turns into busy plus acknowledge. They also check that load-valid follows the acknowledge, that busy is held while a store strobe is awaited, and that busy drops once the flags fall after completion. The lane enables are checked against the length for every legal access and checked to be empty for an illegal one. Only the bench's scenarios can show that the right bytes land in memory and come back, because that needs a memory model. The same holds for unaligned and boundary-crossing accesses, neighbour bytes that must survive, stray strobes, and the dual-flag case.

// File: rtl/lsport_pkg.sv
package lsport_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_LOAD  = 2'd1,
    S_STORE = 2'd2,
    S_DONE  = 2'd3
  } lsport_state_e;
endpackage

// File: rtl/lsport_lane_mask.sv
module lsport_lane_mask #(
  parameter int LANES = 8,
  parameter int LEN_W = 4,
  parameter int OFF_W = 3
) (
  input  logic [LEN_W-1:0] len,
  input  logic [OFF_W-1:0] off,
  output logic [LANES-1:0] be,
  output logic             legal
);
  logic size_ok;

  always_comb begin
    size_ok = 1'b0;
    for (int k = 0; (1 << k) <= LANES; k++) begin
      if (int'(len) == (1 << k)) size_ok = 1'b1;
    end
    legal = size_ok && ((int'(off) + int'(len)) <= LANES);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be[i] = legal && (i >= int'(off)) && (i < int'(off) + int'(len));
  end

  // R5: legal accesses enable exactly len lanes, illegal ones none
  always_comb begin
    if (!$isunknown({len, off})) begin
      p_be_count_r5: assert (legal ? ($countones(be) == int'(len)) : (be == '0));
    end
  end
endmodule

// File: rtl/lsport_st_align.sv
module lsport_st_align #(
  parameter int DATA_W = 64,
  parameter int OFF_W  = 3
) (
  input  logic [DATA_W-1:0] data,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] lanes
);
  assign lanes = data << (8 * int'(off));
endmodule

// File: rtl/lsport_ld_extract.sv
module lsport_ld_extract #(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 4,
  parameter int OFF_W  = 3,
  localparam int LANES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic              legal,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] shifted;
  assign shifted = word >> (8 * int'(off));

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign data[8*i +: 8] = (legal && (i < int'(len))) ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsport_mem_array.sv
module lsport_mem_array #(
  parameter int DATA_W = 64,
  parameter int WORDS  = 32,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) mem[w][8*i +: 8] <= 8'h00;
      end else if (we && be[i]) begin
        mem[idx][8*i +: 8] <= wdata[8*i +: 8];
      end
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/lsport_mem.sv
module lsport_mem #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int LEN_W = OFF_W + 1,
  localparam int WORDS = 2 ** (ADDR_W - OFF_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req_i,
  input  logic              st_req_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_vld_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              st_vld_i,
  output logic              busy_o,
  output logic              addr_ok_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              ld_vld_o
);
  import lsport_pkg::*;

  lsport_state_e     state;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [LANES-1:0]  be;
  logic              legal;
  logic [DATA_W-1:0] wlanes, rword, ext;
  logic              mem_we;
  logic              any_req;

  assign any_req = ld_req_i || st_req_i;
  assign busy_o  = (state != S_IDLE);
  assign mem_we  = (state == S_STORE) && st_vld_i;

  lsport_lane_mask #(.LANES(LANES), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_mask (
    .len(len_q), .off(addr_q[OFF_W-1:0]), .be(be), .legal(legal)
  );

  lsport_st_align #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_align (
    .data(st_data_i), .off(addr_q[OFF_W-1:0]), .lanes(wlanes)
  );

  lsport_mem_array #(.DATA_W(DATA_W), .WORDS(WORDS)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .be(be),
    .idx(addr_q[ADDR_W-1:OFF_W]), .wdata(wlanes), .rdata(rword)
  );

  lsport_ld_extract #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_extract (
    .word(rword), .off(addr_q[OFF_W-1:0]), .len(len_q), .legal(legal), .data(ext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      len_q     <= '0;
      addr_ok_o <= 1'b0;
      ld_vld_o  <= 1'b0;
      ld_data_o <= '0;
    end else begin
      addr_ok_o <= 1'b0;
      ld_vld_o  <= 1'b0;
      unique case (state)
        S_IDLE: if (any_req && addr_vld_i) begin
          addr_q    <= addr_i;
          len_q     <= len_i;
          addr_ok_o <= 1'b1;
          state     <= ld_req_i ? S_LOAD : S_STORE;
        end
        S_LOAD: begin
          ld_data_o <= ext;
          ld_vld_o  <= 1'b1;
          state     <= S_DONE;
        end
        S_STORE: if (st_vld_i) state <= S_DONE;
        S_DONE:  if (!any_req) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && any_req && addr_vld_i) |=> (busy_o && addr_ok_o));
  p_ok_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ok_o |=> !addr_ok_o);
  p_ld_after_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld_o |-> $past(addr_ok_o));
  p_ld_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld_o |=> !ld_vld_o);
  p_wait_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STORE && !st_vld_i) |=> busy_o);
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DONE && !any_req) |=> !busy_o);
endmodule

// File: tb/lsport_mem_test.sv
module lsport_mem_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_req_i = 0, st_req_i = 0, addr_vld_i = 0, st_vld_i = 0;
  logic [3:0]  len_i = 0;
  logic [7:0]  addr_i = 0;
  logic [63:0] st_data_i = 0;
  logic        busy_o, addr_ok_o, ld_vld_o;
  logic [63:0] ld_data_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] model [256];

  lsport_mem uut (
    .clk(clk), .rst_n(rst_n), .ld_req_i(ld_req_i), .st_req_i(st_req_i),
    .len_i(len_i), .addr_i(addr_i), .addr_vld_i(addr_vld_i),
    .st_data_i(st_data_i), .st_vld_i(st_vld_i), .busy_o(busy_o),
    .addr_ok_o(addr_ok_o), .ld_data_o(ld_data_o), .ld_vld_o(ld_vld_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit is_legal(input int a, input int l);
    return (l == 1 || l == 2 || l == 4 || l == 8) && ((a % 8) + l <= 8);
  endfunction

  function automatic logic [63:0] exp_load(input int a, input int l);
    logic [63:0] r = '0;
    if (is_legal(a, l))
      for (int i = 0; i < l; i++) r[8*i +: 8] = model[a + i];
    return r;
  endfunction

  task automatic do_store(input int a, input int l, input logic [63:0] d, input int gap, input int hold);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    st_req_i = 1; len_i = 4'(l); addr_i = 8'(a); addr_vld_i = 1;
    @(negedge clk);
    chk(addr_ok_o && busy_o, "R2 store accept", {62'd0, addr_ok_o, busy_o}, 64'd3);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(busy_o && !addr_ok_o, "R9 wait strobe", {62'd0, addr_ok_o, busy_o}, 64'd1);
    end
    st_data_i = d; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0; st_data_i = {$urandom, $urandom};
    for (int h = 0; h < hold; h++) begin
      chk(busy_o, "R6 busy held by flags", {63'd0, busy_o}, 64'd1);
      @(negedge clk);
    end
    st_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk(!busy_o, "R6 busy drop after store", {63'd0, busy_o}, 64'd0);
    if (is_legal(a, l))
      for (int i = 0; i < l; i++) model[a + i] = d[8*i +: 8];
  endtask

  task automatic do_load(input int a, input int l, input bit both, input string req);
    logic [63:0] e;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    e = exp_load(a, l);
    ld_req_i = 1; st_req_i = both; len_i = 4'(l); addr_i = 8'(a); addr_vld_i = 1;
    @(negedge clk);
    chk(addr_ok_o && !ld_vld_o, "R2 load accept", {62'd0, addr_ok_o, ld_vld_o}, 64'd2);
    @(negedge clk);
    chk(ld_vld_o && !addr_ok_o, "R4 load valid timing", {62'd0, ld_vld_o, addr_ok_o}, 64'd2);
    chk(ld_data_o == e, req, ld_data_o, e);
    ld_req_i = 0; st_req_i = 0; addr_vld_i = 0;
    @(negedge clk);
    chk(!busy_o && !ld_vld_o, "R4 R6 load end", {62'd0, busy_o, ld_vld_o}, 64'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy_o && !addr_ok_o && !ld_vld_o && ld_data_o == 0, "R1 reset outputs",
        {busy_o, addr_ok_o, ld_vld_o, 61'd0} | ld_data_o, 64'd0);
    do_load(8'h10, 8, 0, "R1 memory zero after reset");
    do_load(8'hF8, 8, 0, "R1 memory zero top word");

    // R8 directed halfword case
    do_store(2, 2, 64'h0000_0000_0000_BEEF, 0, 0);
    do_store(4, 2, 64'h0000_0000_0000_F00F, 2, 1);
    do_load(2, 2, 0, "R8 readback 0xBEEF");
    do_load(4, 2, 0, "R8 readback 0xF00F");
    do_load(0, 8, 0, "R3 neighbours intact");

    // R2 no accept without address valid
    @(negedge clk);
    ld_req_i = 1; addr_vld_i = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !addr_ok_o, "R2 no accept without addr valid", {62'd0, busy_o, addr_ok_o}, 64'd0);
    ld_req_i = 0;

    // R6 stray strobe while idle is ignored
    st_data_i = 64'hFFFF_FFFF_FFFF_FFFF; st_vld_i = 1;
    @(negedge clk);
    st_vld_i = 0;
    chk(!busy_o, "R6 stray strobe no busy", {63'd0, busy_o}, 64'd0);
    do_load(2, 2, 0, "R6 stray strobe leaves memory");

    // R5 illegal lengths and boundary crossing
    do_store(8'h20, 8, 64'h0123_4567_89AB_CDEF, 0, 0);
    do_store(8'h21, 3, 64'hAAAA_AAAA_AAAA_AAAA, 1, 0);
    do_store(8'h26, 4, 64'hBBBB_BBBB_BBBB_BBBB, 0, 0);
    do_store(8'h27, 2, 64'hCCCC_CCCC_CCCC_CCCC, 0, 2);
    do_load(8'h20, 8, 0, "R5 illegal stores left memory");
    do_load(8'h25, 4, 0, "R5 crossing load reads zero");
    do_load(8'h20, 0, 0, "R5 zero length reads zero");
    do_load(8'h27, 1, 0, "R4 single byte at top lane");

    // R7 both flags -> load, no write
    do_load(8'h20, 8, 1, "R7 dual flag acts as load");
    do_load(8'h20, 8, 0, "R7 memory unchanged after dual flag");

    // Random mix (R3 R4 R5)
    for (int n = 0; n < 300; n++) begin
      int l, a, pick;
      pick = int'($urandom % 10);
      l = (pick < 3) ? 1 : (pick < 5) ? 2 : (pick < 7) ? 4 : (pick < 9) ? 8 : 3;
      a = int'($urandom % 256);
      if ($urandom % 4 != 0) a = a - (a % (l == 3 ? 1 : l));
      if ($urandom % 2 == 0)
        do_store(a, l, {$urandom, $urandom}, int'($urandom % 3), int'($urandom % 2));
      else
        do_load(a, l, 0, "R3 R4 R5 random load data");
    end
    for (int w = 0; w < 32; w++) do_load(8 * w, 8, 0, "R3 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule